// File: doc/BRIEF.md
# Quadrature CORDIC Oscillator

This block is a numerically controlled oscillator that produces a cosine and a sine sample on every enabled clock. A 32-bit phase register accumulates a programmable tuning word. The register wraps modulo 2^32, so the bits above the extracted field count whole turns and fall away. The upper 16 bits are read as a fraction of one turn. A two-bit quadrant fold first moves that angle into the half-turn centred on zero. A fully pipelined rotation-mode CORDIC then turns the vector through the remaining angle, one micro-rotation per stage.

The rotator is seeded with x = 1/1.64675 and y = 0, so its built-in gain is cancelled in advance and no multiplier follows it. The datapath is 16 bits wide, in the form sign, one guard integer bit and 14 fraction bits. Each output keeps only the top part of that word: a 12-bit two's-complement value with a sign bit and 11 fraction bits, saturated at full scale. The tuning word for an output frequency f_out at a clock f_clk is round(f_out * 2^32 / f_clk). For 40 MHz out of 165 MHz this gives 0x3E0F83E1.

Top module: `nco_cordic_osc`

## Requirements
- R1: While reset is held and afterwards, until the first sample has passed through, out_valid is 0 and cos_out and sin_out are 0.
- R2: Each clock with en high takes the current 32-bit phase as a sample, then adds freq_word to the phase modulo 2^32. A clock with en low leaves the phase unchanged. The first sample after reset has phase 0.
- R3: Only phase bits [31:16] set the angle, as p/65536 of a turn, where bit 31 weighs pi and p = 0x4000 means pi/2. Bits [15:0] have no effect on the sample's outputs.
- R4: For a sample with angle field p, cos_out is within 4 LSB of round(2048*cos(2*pi*p/65536)) and sin_out is within 4 LSB of round(2048*sin(2*pi*p/65536)). Both reference values are clamped to at most 2047. The outputs are signed 12-bit values with 11 fraction bits.
- R5: A sample whose en is sampled at clock edge n appears on the outputs, with out_valid high, right after edge n+STAGES+1. That is edge n+15 with the default of 14 stages.
- R6: On any cycle where out_valid is low, cos_out and sin_out keep the values they had on the previous cycle.
- R7: The two top angle bits select a pre-rotation of 0, +pi/2, -pi/2 or 0 for the codes 00, 01, 10 and 11, so angles in every quadrant are correct. The quarter-turn points 0x0000, 0x4000, 0x8000 and 0xC000 give (2047,0), (0,2047), (-2048,0) and (0,-2048) within 4 LSB.
- R8: Exactly one output with out_valid high is produced for each enabled clock, in order. None is produced for a clock with en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Take a sample and advance the phase this clock |
| freq_word | input | 32 | Phase increment per enabled clock |
| cos_out | output | 12 | Signed cosine sample, sign plus 11 fraction bits |
| sin_out | output | 12 | Signed sine sample, sign plus 11 fraction bits |
| out_valid | output | 1 | High for one cycle with each new sample |

## Verification
The assertions assume that freq_word and en are steady around each rising edge. They also assume that the seed and the stage count keep the rotator's vector norm at or below 1.0 plus a small rounding margin, which bounds the internal x and y values and the residual angle. The bench changes inputs only on falling edges and leaves the seed and stage count at their defaults. Its stimulus mixes a real tuning word, exact quarter turns, a zero word, a word that touches only the discarded low bits, a word that makes the phase wrap, and enable gaps.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // arctangent of 2^-i in radians, by power series (i = 0 handled exactly)
  function automatic real atan_pow2(input int i);
    real x;
    real p;
    real sum;
    real sgn;
    if (i == 0) return 0.7853981633974483;
    x = 1.0;
    for (int k = 0; k < i; k++) x = x / 2.0;
    p   = x;
    sum = 0.0;
    sgn = 1.0;
    for (int n = 0; n < 24; n++) begin
      sum = sum + sgn * p / real'(2 * n + 1);
      p   = p * x * x;
      sgn = -sgn;
    end
    return sum;
  endfunction

  // same angle in units where 2^ph_w is one full turn
  function automatic int atan_units(input int i, input int ph_w);
    real turns;
    real scale;
    scale = 1.0;
    for (int k = 0; k < ph_w; k++) scale = scale * 2.0;
    turns = atan_pow2(i) / 6.283185307179586;
    return $rtoi(turns * scale + 0.5);
  endfunction

  // 1/1.64675 with frac_w fraction bits
  function automatic int gain_seed(input int frac_w);
    real scale;
    scale = 1.0;
    for (int k = 0; k < frac_w; k++) scale = scale * 2.0;
    return $rtoi(scale / 1.64675 + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  output logic [PH_W-1:0]  phase
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign phase = acc_q[ACC_W-1 -: PH_W];

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc_q == $past(acc_q) + $past(step));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

endmodule

// File: rtl/nco_prerotate.sv
module nco_prerotate #(
  parameter int PH_W  = 16,
  parameter int DP_W  = 16,
  parameter int ANG_W = PH_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic [PH_W-1:0]         phase_i,
  output logic                    vld_o,
  output logic signed [DP_W-1:0]  x_o,
  output logic signed [DP_W-1:0]  y_o,
  output logic signed [ANG_W-1:0] z_o
);

  localparam logic signed [DP_W-1:0]  SEED = DP_W'(nco_pkg::gain_seed(DP_W - 2));
  localparam logic signed [ANG_W-1:0] QTR  = ANG_W'(2 ** (PH_W - 2));

  logic signed [ANG_W-1:0] ang;
  logic signed [DP_W-1:0]  x_d, y_d;
  logic signed [ANG_W-1:0] z_d;
  logic                    vld_q;
  logic signed [DP_W-1:0]  x_q, y_q;
  logic signed [ANG_W-1:0] z_q;

  assign ang = {phase_i[PH_W-1], phase_i};

  always_comb begin
    unique case (phase_i[PH_W-1 -: 2])
      2'b01: begin x_d = '0;   y_d = SEED;  z_d = ang - QTR; end
      2'b10: begin x_d = '0;   y_d = -SEED; z_d = ang + QTR; end
      default: begin x_d = SEED; y_d = '0;  z_d = ang;       end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        x_q <= x_d;
        y_q <= y_d;
        z_q <= z_d;
      end
    end
  end

  assign vld_o = vld_q;
  assign x_o   = x_q;
  assign y_o   = y_q;
  assign z_o   = z_q;

  a_r7_fold: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (z_q <= QTR && z_q >= -QTR));

endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
  parameter int DP_W  = 16,
  parameter int ANG_W = 17,
  parameter int SHIFT = 0,
  parameter int ATAN  = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic signed [DP_W-1:0]  x_i,
  input  logic signed [DP_W-1:0]  y_i,
  input  logic signed [ANG_W-1:0] z_i,
  output logic                    vld_o,
  output logic signed [DP_W-1:0]  x_o,
  output logic signed [DP_W-1:0]  y_o,
  output logic signed [ANG_W-1:0] z_o
);

  localparam logic signed [ANG_W-1:0] ATAN_C = ANG_W'(ATAN);
  localparam logic signed [DP_W-1:0]  NLIM   = DP_W'(2 ** (DP_W - 2) + 64);

  logic signed [DP_W-1:0]  xs, ys, x_d, y_d;
  logic signed [ANG_W-1:0] z_d;
  logic                    vld_q;
  logic signed [DP_W-1:0]  x_q, y_q;
  logic signed [ANG_W-1:0] z_q;

  assign xs = x_i >>> SHIFT;
  assign ys = y_i >>> SHIFT;

  always_comb begin
    if (!z_i[ANG_W-1]) begin
      x_d = x_i - ys;
      y_d = y_i + xs;
      z_d = z_i - ATAN_C;
    end else begin
      x_d = x_i + ys;
      y_d = y_i - xs;
      z_d = z_i + ATAN_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        x_q <= x_d;
        y_q <= y_d;
        z_q <= z_d;
      end
    end
  end

  assign vld_o = vld_q;
  assign x_o   = x_q;
  assign y_o   = y_q;
  assign z_o   = z_q;

  // R4: vector norm stays at or below 1.0 (plus rounding), so nothing wraps
  a_r4_norm: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (x_q <= NLIM && x_q >= -NLIM && y_q <= NLIM && y_q >= -NLIM));

endmodule

// File: rtl/nco_out_quant.sv
module nco_out_quant #(
  parameter int DP_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic signed [DP_W-1:0]  x_i,
  input  logic signed [DP_W-1:0]  y_i,
  output logic                    vld_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);

  localparam int DROP = DP_W - OUT_W - 1;
  localparam logic signed [DP_W-1:0] HI = DP_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [DP_W-1:0] LO = -DP_W'(2 ** (OUT_W - 1));

  logic signed [DP_W-1:0]  xs, ys;
  logic signed [OUT_W-1:0] c_d, s_d;
  logic                    vld_q;
  logic signed [OUT_W-1:0] c_q, s_q;

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [DP_W-1:0] v);
    if (v > HI)      return HI[OUT_W-1:0];
    else if (v < LO) return LO[OUT_W-1:0];
    else             return v[OUT_W-1:0];
  endfunction

  assign xs = x_i >>> DROP;
  assign ys = y_i >>> DROP;

  always_comb begin
    c_d = sat(xs);
    s_d = sat(ys);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      c_q   <= '0;
      s_q   <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        c_q <= c_d;
        s_q <= s_d;
      end
    end
  end

  assign vld_o = vld_q;
  assign cos_o = c_q;
  assign sin_o = s_q;

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> ($stable(c_q) && $stable(s_q)));

endmodule

// File: rtl/nco_cordic_osc.sv
module nco_cordic_osc #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 16,
  parameter int DP_W   = 16,
  parameter int OUT_W  = 12,
  parameter int STAGES = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ACC_W-1:0]        freq_word,
  output logic signed [OUT_W-1:0] cos_out,
  output logic signed [OUT_W-1:0] sin_out,
  output logic                    out_valid
);

  localparam int ANG_W = PH_W + 1;
  localparam logic signed [ANG_W-1:0] ZRES = ANG_W'(12);

  logic [1:0]      rst_sync_q;
  logic            rst_i_n;
  logic [PH_W-1:0] phase;

  logic                    vld_s [STAGES+1];
  logic signed [DP_W-1:0]  x_s   [STAGES+1];
  logic signed [DP_W-1:0]  y_s   [STAGES+1];
  logic signed [ANG_W-1:0] z_s   [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_i_n), .en(en), .step(freq_word), .phase(phase)
  );

  nco_prerotate #(.PH_W(PH_W), .DP_W(DP_W), .ANG_W(ANG_W)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .vld_i(en), .phase_i(phase),
    .vld_o(vld_s[0]), .x_o(x_s[0]), .y_o(y_s[0]), .z_o(z_s[0])
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    nco_cordic_stage #(
      .DP_W(DP_W), .ANG_W(ANG_W), .SHIFT(g),
      .ATAN(nco_pkg::atan_units(g, PH_W))
    ) u_stage (
      .clk(clk), .rst_n(rst_i_n), .vld_i(vld_s[g]),
      .x_i(x_s[g]), .y_i(y_s[g]), .z_i(z_s[g]),
      .vld_o(vld_s[g+1]), .x_o(x_s[g+1]), .y_o(y_s[g+1]), .z_o(z_s[g+1])
    );
  end

  nco_out_quant #(.DP_W(DP_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_i_n), .vld_i(vld_s[STAGES]),
    .x_i(x_s[STAGES]), .y_i(y_s[STAGES]),
    .vld_o(out_valid), .cos_o(cos_out), .sin_o(sin_out)
  );

  // R4: the residual angle after the last stage is close to zero
  a_r4_converged: assert property (@(posedge clk) disable iff (!rst_i_n)
    vld_s[STAGES] |-> (z_s[STAGES] <= ZRES && z_s[STAGES] >= -ZRES));

endmodule

// File: tb/nco_cordic_osc_bench.sv
module nco_cordic_osc_bench;

  localparam int STAGES = 14;
  localparam int TOL    = 4;
  localparam real TWO_PI = 6.283185307179586;

  typedef struct {
    int    ang;
    int    stamp;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] freq_word;
  logic signed [11:0] cos_out, sin_out;
  logic        out_valid;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    outs = 0;
  int    pushes = 0;
  bit    done = 0;
  logic [31:0] model_acc;
  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nco_cordic_osc u_nco_cordic_osc (
    .clk(clk), .rst_n(rst_n), .en(en), .freq_word(freq_word),
    .cos_out(cos_out), .sin_out(sin_out), .out_valid(out_valid)
  );

  function automatic int ref_val(input int ang, input bit want_sin);
    real a, v;
    int r;
    a = TWO_PI * real'(ang) / 65536.0;
    v = want_sin ? 2048.0 * $sin(a) : 2048.0 * $cos(a);
    r = int'(v);
    if (r > 2047) r = 2047;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] fw, input int n, input bit gaps, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      freq_word = fw;
      en = gaps ? ((i % 3) != 1) : 1'b1;
      if (en) begin
        item_t it;
        it.ang   = int'(model_acc[31:16]);
        it.stamp = cyc + 1;
        it.tag   = tag;
        sb.push_back(it);
        pushes++;
        model_acc = model_acc + fw;
      end
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (out_valid) begin
      outs++;
      if (sb.size() == 0) begin
        check(1'b0, "R8 extra output", outs, pushes);
      end else begin
        item_t it;
        int ec, es;
        it = sb.pop_front();
        ec = ref_val(it.ang, 1'b0);
        es = ref_val(it.ang, 1'b1);
        check((int'(cos_out) - ec <= TOL) && (ec - int'(cos_out) <= TOL),
              {"R4 cos ", it.tag}, int'(cos_out), ec);
        check((int'(sin_out) - es <= TOL) && (es - int'(sin_out) <= TOL),
              {"R4 sin ", it.tag}, int'(sin_out), es);
        check(cyc == it.stamp + STAGES + 1, "R5 latency", cyc - it.stamp, STAGES + 1);
      end
    end
  end

  // R6: outputs hold between valid samples
  logic signed [11:0] prev_c, prev_s;
  always @(negedge clk) begin
    if (rst_n && !out_valid && cyc > 4 && !done) begin
      if (cos_out !== prev_c || sin_out !== prev_s)
        check(1'b0, "R6 hold", int'(cos_out), int'(prev_c));
    end
    prev_c <= cos_out;
    prev_s <= sin_out;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    freq_word = '0;
    model_acc = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(cos_out == 12'sd0, "R1 cos after reset", int'(cos_out), 0);
    check(sin_out == 12'sd0, "R1 sin after reset", int'(sin_out), 0);

    drive(32'h4000_0000, 12, 1'b0, "R7 quarter turns");
    drive(32'h3E0F_83E1, 60, 1'b0, "R2 tuning word");
    drive(32'h0123_4567, 30, 1'b1, "R8 enable gaps");
    drive(32'h0000_0000, 8,  1'b0, "R2 zero word");
    drive(32'h0000_FFFF, 8,  1'b0, "R3 low bits");
    drive(32'h9E37_79B9, 40, 1'b0, "R2 wrap");
    drive(32'hC000_0001, 16, 1'b0, "R7 reverse");
    repeat (STAGES + 10) @(negedge clk);

    check(sb.size() == 0, "R8 pending samples", sb.size(), 0);
    check(outs == pushes, "R8 output count", outs, pushes);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule